// File: doc/BRIEF.md
# Data Cache with Deferred Store Write

A direct-mapped, write-back data cache for one pipelined processor port. A load checks the tag and reads the data array together, and its result comes back one cycle after the request is accepted. A store only checks its tag when it is accepted. Its word is then held in a one-entry store buffer, and the word is written into the array in the cycle the next store is accepted. Every store therefore makes one pass down the pipe and needs no stall of its own.

Because a buffered word is not yet in the array, every load compares its word address with the buffer. On a match, the buffered bytes are laid over the array bytes before the load result is registered. On a miss the block raises `stall` and holds it until the line is in place. If the victim line is dirty, it is written back first. A buffered store in the victim's set is drained into the line before eviction.

A flush input drains the buffer and then sweeps all sets, writing back dirty lines. After a flush, the external memory holds every store the cache accepted. The defaults are a 32-bit address, 32-bit data, 16-byte lines and 64 sets.

Top module: `dc_cache`

## Requirements
- R1: While reset is held and right after it, `stall`, `rsp_valid` and `mem_valid` are low. Every line starts invalid, so the first access to any set misses.
- R2: A load is accepted in a cycle where `req_valid` is high, `req_write` is low and `stall` is low. `rsp_valid` is then high in the following cycle only, and `rsp_rdata` holds the word. `rsp_valid` is never high otherwise.
- R3: A store whose line is resident is accepted in its request cycle, with `stall` low. It starts no memory transaction and produces no response.
- R4: A load of the word held in the store buffer returns the buffered data, even though that data has not yet been written into the array.
- R5: Byte lane b is bits 8b+7..8b. For a load that matches a store buffered with partial byte enables, lanes whose `req_be` bit was set come from the buffer and the other lanes come from the array.
- R6: A load or store miss raises `stall` in its request cycle and keeps it high until the line is installed. The block issues exactly one read with `mem_write` low, at the line address (low 4 address bits zero). The request then completes as a hit.
- R7: If the victim line is valid and dirty, it is written back before the read, with `mem_write` high and the victim's line address. Word w of a line is `mem_wline`/`mem_rline` bits 32w+31..32w, at line address + 4w, and the written line holds every store accepted to it.
- R8: A buffered store in the set of a missing request is written into its line before eviction, so its data reaches memory and a later load of that word returns it.
- R9: A miss whose victim is invalid or clean issues no write.
- R10: Flush first drains the buffer. It then visits sets in ascending index order and writes each dirty line exactly once. Afterwards memory matches all accepted stores, and the lines remain valid and clean, so a second flush writes nothing.
- R11: While `mem_valid` is high and `mem_ack` is low, the request stays asserted, and `mem_addr` and `mem_write` stay unchanged.
- R12: `flush` takes priority over a request. `stall` is high in the cycle `flush` is raised, a request presented in that cycle is not accepted, and the request completes once the flush ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load/store request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address (word aligned) |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables, bit b = lane b |
| flush | input | 1 | Drain buffer and write back all dirty lines |
| stall | output | 1 | Request not accepted this cycle; hold it |
| rsp_valid | output | 1 | Load result valid |
| rsp_rdata | output | 32 | Load result |
| mem_valid | output | 1 | Memory request pending |
| mem_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wline | output | 128 | Line written back |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rline | input | 128 | Line returned by a read, valid with `mem_ack` |

## Verification
Two things can happen in the same cycle. The previous store's word is written into the array while the next store is checked and captured. A load is also served while its word is still only in the buffer, so the result is merged from both. Random traffic folded onto four sets and four tags, with back-to-back stores and loads and random byte enables, makes these collisions frequent. Directed sequences force the drain-before-eviction and flush-with-request cases. Each load result and each written-back line is compared word by word with a bench reference memory, and a final flush checks the whole memory image.

// File: rtl/dc_pkg.sv
package dc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_EVICT    = 3'd1,
        ST_REFILL   = 3'd2,
        ST_SWEEP    = 3'd3,
        ST_SWEEP_WB = 3'd4
    } dc_state_e;

endpackage

// File: rtl/dc_byte_merge.sv
module dc_byte_merge #(
    parameter int BYTES = 4
) (
    input  logic [BYTES*8-1:0] base_i,
    input  logic [BYTES*8-1:0] over_i,
    input  logic [BYTES-1:0]   sel_i,
    output logic [BYTES*8-1:0] y_o
);

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign y_o[b*8 +: 8] = sel_i[b] ? over_i[b*8 +: 8] : base_i[b*8 +: 8];
    end

endmodule

// File: rtl/dc_line_patch.sv
module dc_line_patch #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int BE_W   = DATA_W / 8,
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [WORDS*DATA_W-1:0] line_i,
    input  logic [WSEL_W-1:0]       wsel_i,
    input  logic [DATA_W-1:0]       word_i,
    input  logic [BE_W-1:0]         be_i,
    output logic [WORDS*DATA_W-1:0] line_o
);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [BE_W-1:0] lane_en;
        assign lane_en = (wsel_i == WSEL_W'(w)) ? be_i : '0;

        dc_byte_merge #(.BYTES(BE_W)) u_merge (
            .base_i (line_i[w*DATA_W +: DATA_W]),
            .over_i (word_i),
            .sel_i  (lane_en),
            .y_o    (line_o[w*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/dc_cache.sv
module dc_cache
    import dc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int SETS       = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [DATA_W/8-1:0]     req_be,
    input  logic                    flush,
    output logic                    stall,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic                    mem_valid,
    output logic                    mem_write,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LINE_BYTES*8-1:0] mem_wline,
    input  logic                    mem_ack,
    input  logic [LINE_BYTES*8-1:0] mem_rline
);

    localparam int BE_W    = DATA_W / 8;
    localparam int WORDS   = LINE_BYTES / BE_W;
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam int BSEL_W  = $clog2(BE_W);
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int WADDR_W = ADDR_W - BSEL_W;
    localparam int LADDR_W = ADDR_W - OFF_W;

    typedef struct packed {
        dc_state_e                                state;
        logic [SETS-1:0]                          valid;
        logic [SETS-1:0]                          dirty;
        logic [SETS-1:0][TAG_W-1:0]               tag;
        logic [SETS-1:0][WORDS-1:0][DATA_W-1:0]   line;
        logic                                     sb_v;
        logic [WADDR_W-1:0]                       sb_waddr;
        logic [DATA_W-1:0]                        sb_data;
        logic [BE_W-1:0]                          sb_be;
        logic [LADDR_W-1:0]                       miss_laddr;
        logic [IDX_W-1:0]                         sweep_idx;
        logic                                     rsp_v;
        logic [DATA_W-1:0]                        rsp_data;
    } dc_regs_t;

    dc_regs_t st_d, st_q;

    // request decode
    logic [TAG_W-1:0]   req_tag;
    logic [IDX_W-1:0]   req_idx;
    logic [WSEL_W-1:0]  req_wsel;
    logic [WADDR_W-1:0] req_waddr;
    logic [LADDR_W-1:0] req_laddr;
    logic               req_hit;

    assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx   = req_addr[OFF_W +: IDX_W];
    assign req_wsel  = req_addr[BSEL_W +: WSEL_W];
    assign req_waddr = req_addr[ADDR_W-1:BSEL_W];
    assign req_laddr = req_addr[ADDR_W-1:OFF_W];
    assign req_hit   = st_q.valid[req_idx] && (st_q.tag[req_idx] == req_tag);

    // store buffer decode and drain image
    logic [IDX_W-1:0]  sb_idx;
    logic [WSEL_W-1:0] sb_wsel;
    logic [LINE_W-1:0] sb_line_now;
    logic [LINE_W-1:0] sb_line_drained;

    assign sb_idx      = st_q.sb_waddr[WSEL_W +: IDX_W];
    assign sb_wsel     = st_q.sb_waddr[WSEL_W-1:0];
    assign sb_line_now = st_q.line[sb_idx];

    dc_line_patch #(.WORDS(WORDS), .DATA_W(DATA_W)) u_drain (
        .line_i (sb_line_now),
        .wsel_i (sb_wsel),
        .word_i (st_q.sb_data),
        .be_i   (st_q.sb_be),
        .line_o (sb_line_drained)
    );

    // load bypass: buffered lanes over array lanes
    logic [WORDS-1:0][DATA_W-1:0] req_line;
    logic [DATA_W-1:0]            arr_word;
    logic                         sb_match;
    logic [BE_W-1:0]              byp_en;
    logic [DATA_W-1:0]            load_word;

    assign req_line = st_q.line[req_idx];
    assign arr_word = req_line[req_wsel];
    assign sb_match = st_q.sb_v && (st_q.sb_waddr == req_waddr);
    assign byp_en   = sb_match ? st_q.sb_be : '0;

    dc_byte_merge #(.BYTES(BE_W)) u_bypass (
        .base_i (arr_word),
        .over_i (st_q.sb_data),
        .sel_i  (byp_en),
        .y_o    (load_word)
    );

    // miss bookkeeping
    logic [IDX_W-1:0] miss_idx;
    logic [TAG_W-1:0] miss_tag;

    assign miss_idx = st_q.miss_laddr[IDX_W-1:0];
    assign miss_tag = st_q.miss_laddr[LADDR_W-1:IDX_W];

    // memory port
    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_wline = '0;
        unique case (st_q.state)
            ST_EVICT: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {st_q.tag[miss_idx], miss_idx, {OFF_W{1'b0}}};
                mem_wline = st_q.line[miss_idx];
            end
            ST_REFILL: begin
                mem_valid = 1'b1;
                mem_addr  = {st_q.miss_laddr, {OFF_W{1'b0}}};
            end
            ST_SWEEP_WB: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {st_q.tag[st_q.sweep_idx], st_q.sweep_idx, {OFF_W{1'b0}}};
                mem_wline = st_q.line[st_q.sweep_idx];
            end
            default: ;
        endcase
    end

    assign stall     = (st_q.state != ST_IDLE) || flush || (req_valid && !req_hit);
    assign rsp_valid = st_q.rsp_v;
    assign rsp_rdata = st_q.rsp_data;

    // next state
    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = 1'b0;

        unique case (st_q.state)
            ST_IDLE: begin
                if (flush) begin
                    if (st_q.sb_v) begin
                        st_d.line[sb_idx] = sb_line_drained;
                        st_d.sb_v         = 1'b0;
                    end
                    st_d.sweep_idx = '0;
                    st_d.state     = ST_SWEEP;
                end else if (req_valid && req_hit) begin
                    if (req_write) begin
                        if (st_q.sb_v) begin
                            st_d.line[sb_idx] = sb_line_drained;
                        end
                        st_d.sb_v           = 1'b1;
                        st_d.sb_waddr       = req_waddr;
                        st_d.sb_data        = req_wdata;
                        st_d.sb_be          = req_be;
                        st_d.dirty[req_idx] = 1'b1;
                    end else begin
                        st_d.rsp_v    = 1'b1;
                        st_d.rsp_data = load_word;
                    end
                end else if (req_valid) begin
                    if (st_q.sb_v && (sb_idx == req_idx)) begin
                        st_d.line[sb_idx] = sb_line_drained;
                        st_d.sb_v         = 1'b0;
                    end
                    st_d.miss_laddr = req_laddr;
                    if (st_q.valid[req_idx] && st_q.dirty[req_idx]) begin
                        st_d.state = ST_EVICT;
                    end else begin
                        st_d.state = ST_REFILL;
                    end
                end
            end
            ST_EVICT: begin
                if (mem_ack) begin
                    st_d.dirty[miss_idx] = 1'b0;
                    st_d.state           = ST_REFILL;
                end
            end
            ST_REFILL: begin
                if (mem_ack) begin
                    st_d.line[miss_idx]  = mem_rline;
                    st_d.tag[miss_idx]   = miss_tag;
                    st_d.valid[miss_idx] = 1'b1;
                    st_d.dirty[miss_idx] = 1'b0;
                    st_d.state           = ST_IDLE;
                end
            end
            ST_SWEEP: begin
                if (st_q.valid[st_q.sweep_idx] && st_q.dirty[st_q.sweep_idx]) begin
                    st_d.state = ST_SWEEP_WB;
                end else if (st_q.sweep_idx == IDX_W'(SETS - 1)) begin
                    st_d.state = ST_IDLE;
                end else begin
                    st_d.sweep_idx = st_q.sweep_idx + IDX_W'(1);
                end
            end
            ST_SWEEP_WB: begin
                if (mem_ack) begin
                    st_d.dirty[st_q.sweep_idx] = 1'b0;
                    if (st_q.sweep_idx == IDX_W'(SETS - 1)) begin
                        st_d.state = ST_IDLE;
                    end else begin
                        st_d.sweep_idx = st_q.sweep_idx + IDX_W'(1);
                        st_d.state     = ST_SWEEP;
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dc_cache_chk.sv
module dc_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              flush,
    input logic              stall,
    input logic              rsp_valid,
    input logic              mem_valid,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);

    AST_LOAD_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !stall) |=> rsp_valid); // R2

    AST_RSP_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write && !stall)); // R2

    AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R11

    AST_MEM_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[OFF_W-1:0] == '0)); // R6

    AST_MEM_MEANS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> stall); // R6

    AST_FLUSH_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> stall); // R12

endmodule

bind dc_cache dc_cache_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .flush     (flush),
    .stall     (stall),
    .rsp_valid (rsp_valid),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack)
);

// File: tb/sim_dc_cache.sv
`timescale 1ns/1ps
module sim_dc_cache;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [3:0]   req_be = '0;
    logic         flush = 1'b0;
    logic         stall;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         mem_valid;
    logic         mem_write;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wline;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rline = '0;

    dc_cache u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .flush(flush),
        .stall(stall), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wline(mem_wline), .mem_ack(mem_ack), .mem_rline(mem_rline)
    );

    always #4 clk = ~clk;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [31:0] refm [1024];
    logic [31:0] bmem [1024];
    logic        mval [64];
    logic [21:0] mtag [64];
    logic        mdirty [64];
    int wr_cnt = 0;
    int rd_cnt = 0;
    bit fl_mode = 1'b0;
    int last_fl = -1;
    int order_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] merge_be(input logic [31:0] old_w, input logic [31:0] new_w,
                                             input logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
        return r;
    endfunction

    // memory model with random response delay
    initial begin : mem_model
        int dly;
        bit pend;
        logic [31:0] pend_addr;
        dly = 1;
        pend = 1'b0;
        pend_addr = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                dly = int'($urandom % 3);
                pend = 1'b0;
            end else if (mem_valid) begin
                if (pend) chk(mem_addr == pend_addr, "R11 request address held", mem_addr, pend_addr);
                pend = 1'b1;
                pend_addr = mem_addr;
                if (dly == 0) begin
                    int base;
                    base = int'(mem_addr[11:4]) * 4;
                    if (mem_write) begin
                        for (int w = 0; w < 4; w++) begin
                            chk(mem_wline[w*32 +: 32] == refm[base+w], "R7 R8 written-back word",
                                mem_wline[w*32 +: 32], refm[base+w]);
                            bmem[base+w] = mem_wline[w*32 +: 32];
                        end
                        wr_cnt++;
                        if (fl_mode) begin
                            if (int'(mem_addr[9:4]) <= last_fl) order_bad++;
                            last_fl = int'(mem_addr[9:4]);
                        end
                    end else begin
                        for (int w = 0; w < 4; w++) mem_rline[w*32 +: 32] = bmem[base+w];
                        rd_cnt++;
                    end
                    mem_ack = 1'b1;
                end else begin
                    dly--;
                end
            end
        end
    end

    function automatic int dirty_count();
        int n = 0;
        for (int s = 0; s < 64; s++) if (mval[s] && mdirty[s]) n++;
        return n;
    endfunction

    // one request; starts and ends on a falling edge
    task automatic issue(input bit we, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, input bit with_fl);
        int idx, wi, wr0, rd0, fl_exp;
        logic [21:0] tg;
        bit miss, wb;
        idx = int'(a[9:4]);
        wi = int'(a[11:2]);
        tg = a[31:10];
        wr0 = wr_cnt;
        rd0 = rd_cnt;
        fl_exp = 0;
        if (with_fl) begin
            fl_exp = dirty_count();
            for (int s = 0; s < 64; s++) mdirty[s] = 1'b0;
            fl_mode = 1'b1;
            last_fl = -1;
            order_bad = 0;
        end
        miss = !(mval[idx] && mtag[idx] == tg);
        wb = miss && mval[idx] && mdirty[idx];
        req_valid = 1'b1;
        req_write = we;
        req_addr = a;
        req_wdata = d;
        req_be = be;
        flush = with_fl;
        #1;
        if (with_fl) begin
            chk(stall === 1'b1, "R12 stall when flush meets request", 32'(stall), 32'd1);
            @(negedge clk);
            flush = 1'b0;
            #1;
        end else begin
            chk(stall === miss, "R3 R6 stall in request cycle", 32'(stall), 32'(miss));
        end
        while (stall) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        if (with_fl) begin
            fl_mode = 1'b0;
            chk(order_bad == 0, "R10 flush ascending set order", 32'(order_bad), 32'd0);
        end
        chk(wr_cnt - wr0 == fl_exp + int'(wb), "R7 R9 R10 write-back count",
            32'(wr_cnt - wr0), 32'(fl_exp + int'(wb)));
        chk(rd_cnt - rd0 == int'(miss), "R6 line read count", 32'(rd_cnt - rd0), 32'(miss));
        if (!we) begin
            chk(rsp_valid === 1'b1 && rsp_rdata === refm[wi], "R2 R4 R5 load result",
                rsp_rdata, refm[wi]);
        end else begin
            chk(rsp_valid === 1'b0, "R3 no response for store", 32'(rsp_valid), 32'd0);
        end
        if (miss) begin
            mval[idx] = 1'b1;
            mtag[idx] = tg;
            mdirty[idx] = 1'b0;
        end
        if (we) begin
            mdirty[idx] = 1'b1;
            refm[wi] = merge_be(refm[wi], d, be);
        end
        req_valid = 1'b0;
    endtask

    task automatic do_flush();
        int wr0, fl_exp;
        wr0 = wr_cnt;
        fl_exp = dirty_count();
        for (int s = 0; s < 64; s++) mdirty[s] = 1'b0;
        fl_mode = 1'b1;
        last_fl = -1;
        order_bad = 0;
        req_valid = 1'b0;
        flush = 1'b1;
        #1;
        chk(stall === 1'b1, "R12 stall while flushing", 32'(stall), 32'd1);
        @(negedge clk);
        flush = 1'b0;
        #1;
        while (stall) begin
            @(negedge clk);
            #1;
        end
        fl_mode = 1'b0;
        chk(order_bad == 0, "R10 flush ascending set order", 32'(order_bad), 32'd0);
        chk(wr_cnt - wr0 == fl_exp, "R10 flush write-back count", 32'(wr_cnt - wr0), 32'(fl_exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        void'($urandom(32'd20241));
        for (int i = 0; i < 1024; i++) begin
            refm[i] = 32'(i) * 32'h9E37_79B1 + 32'h0101_0101;
            bmem[i] = refm[i];
        end
        for (int s = 0; s < 64; s++) begin
            mval[s] = 1'b0;
            mtag[s] = '0;
            mdirty[s] = 1'b0;
        end
        repeat (3) @(negedge clk);
        #1;
        chk(stall === 1'b0 && rsp_valid === 1'b0 && mem_valid === 1'b0, "R1 outputs in reset",
            {29'd0, stall, rsp_valid, mem_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(stall === 1'b0 && rsp_valid === 1'b0 && mem_valid === 1'b0, "R1 outputs after reset",
            {29'd0, stall, rsp_valid, mem_valid}, 32'd0);
        @(negedge clk);

        // R1 R6: first access misses
        issue(1'b0, 32'h0000_0000, '0, 4'h0, 1'b0);
        // R3 store hit, R4 bypass
        issue(1'b1, 32'h0000_0004, 32'hCAFE_F00D, 4'hF, 1'b0);
        issue(1'b0, 32'h0000_0004, '0, 4'h0, 1'b0);
        // R5 partial enables merged over array bytes
        issue(1'b1, 32'h0000_0008, 32'h11AA_22BB, 4'b0101, 1'b0);
        issue(1'b0, 32'h0000_0008, '0, 4'h0, 1'b0);
        // next store drains previous; load then reads the array
        issue(1'b1, 32'h0000_000C, 32'h0BAD_BEEF, 4'b1100, 1'b0);
        issue(1'b0, 32'h0000_0008, '0, 4'h0, 1'b0);
        // R8 R7: conflicting miss drains buffered store then evicts dirty line
        issue(1'b0, 32'h0000_0400, '0, 4'h0, 1'b0);
        issue(1'b0, 32'h0000_000C, '0, 4'h0, 1'b0);
        // R9 clean victim
        issue(1'b0, 32'h0000_0800, '0, 4'h0, 1'b0);
        // R12 flush with a waiting request, R10 ordering
        issue(1'b1, 32'h0000_0810, 32'h5555_AAAA, 4'hF, 1'b0);
        issue(1'b1, 32'h0000_0020, 32'h1234_5678, 4'hF, 1'b0);
        issue(1'b0, 32'h0000_0810, '0, 4'h0, 1'b1);
        // R10 second flush writes nothing
        do_flush();
        @(negedge clk);

        for (int i = 0; i < 2500; i++) begin
            int r;
            logic [31:0] a;
            logic [3:0] be;
            r = int'($urandom % 100);
            a = '0;
            a[11:10] = 2'($urandom % 4);
            a[9:4] = ($urandom % 4 == 0) ? 6'($urandom % 64) : 6'($urandom % 4);
            a[3:2] = 2'($urandom % 4);
            be = ($urandom % 2 == 0) ? 4'hF : 4'(($urandom % 15) + 1);
            if (r < 45) issue(1'b1, a, $urandom, be, 1'b0);
            else if (r < 93) issue(1'b0, a, '0, 4'h0, 1'b0);
            else if (r < 98) @(negedge clk);
            else issue(1'b0, a, '0, 4'h0, 1'b1);
        end

        // R10 final memory image
        do_flush();
        for (int i = 0; i < 1024; i++)
            chk(bmem[i] == refm[i], "R10 memory image after flush", bmem[i], refm[i]);
        do_flush();
        @(negedge clk);
        finish_run();
    end

endmodule